// File: doc/BRIEF.md
# Burst Remaining-Count Status Tracker

This block follows a burst that the local bus master runs and, when that transaction ends, records how far it got. A programmed length is loaded into a phase counter when a master transaction begins. The counter then steps down once for every completed data phase. A termination event carries its cause: normal completion, target retry, target disconnect, target abort, master abort or master time-out. When such an event arrives while the block acts as bus master, a 24-bit read-only status word is rewritten. The new word holds the cause as a single flag and the number of data phases still owed, minus one.

The protocol engine drives the phase strobes and the termination inputs. Software or a neighbouring register file reads the status word. The stored count leaves out the phase that is always implied, so a value of 2 means three words are still owed. On normal completion, and whenever counting is switched off, the count is forced to zero.

Top module: `burst_stat_tracker`

## Requirements
- R1: A synchronous active-high `rst` clears the status word to zero at the next clock edge, and it also clears the phase counter.
- R2: Status layout: the remaining count sits in bits 21..16. The flags are master time-out in bit 0, retry in bit 1, disconnect in bit 2, target abort in bit 4 and master abort in bit 5. Every other bit always reads zero.
- R3: `start_i` loads `burst_len_i` (the number of data phases, 0..63) into the phase counter. Each `phase_done_i` then lowers the counter by one, and the counter stays at zero once it gets there.
- R4: The status word changes only in the clock edge that follows a cycle with `term_valid_i`=1 and `master_i`=1. In every other case it holds its value.
- R5: Cause code 0 is normal completion. It writes a count of zero and leaves all flags at zero.
- R6: Early termination (codes 1..5) with `cnt_en_i`=1 stores the outstanding phases minus one, where outstanding = counter minus one if `phase_done_i` is high in the same cycle and the counter is nonzero. If nothing is outstanding, the stored count is zero.
- R7: Early termination with `cnt_en_i`=0 sets the cause flag and stores a count of zero.
- R8: Cause codes map to flags as 1 retry, 2 disconnect, 3 target abort, 4 master abort and 5 master time-out. At most one flag is set at any time.
- R9: Cause codes 6 and 7 are ignored and leave the status word unchanged.
- R10: If `start_i` and `phase_done_i` are both high in one cycle, the reload wins and that strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin of a master transaction; reloads the phase counter |
| burst_len_i | input | 6 | Programmed burst length in data phases |
| cnt_en_i | input | 1 | Phase counting enabled |
| master_i | input | 1 | Block is acting as bus master |
| phase_done_i | input | 1 | One data phase completed |
| term_valid_i | input | 1 | Transaction termination event |
| term_cause_i | input | 3 | Termination cause code |
| status_o | output | 24 | Read-only status word |

## Verification
The bench targets the minus-one encoding in several cases: a burst that is nearly complete, a burst with nothing left, and a full 63-phase burst ended at once. A design that stored the raw outstanding count, or that wrapped below zero, would give a wrong value in bits 21..16. It also lands a phase strobe in the same cycle as a termination and in the same cycle as a reload, where an off-by-one in the ordering would show. Terminations are also applied while not master, with unknown codes, and with counting disabled; a design that updated anyway, or that kept a stale count, would show a changed or nonzero field.

// File: rtl/burst_stat_pkg.sv
package burst_stat_pkg;

    localparam int CNT_W  = 6;
    localparam int STAT_W = 24;

    localparam int RC_LSB      = 16;
    localparam int BIT_TIMEOUT = 0;
    localparam int BIT_RETRY   = 1;
    localparam int BIT_DISC    = 2;
    localparam int BIT_TABORT  = 4;
    localparam int BIT_MABORT  = 5;

    typedef logic [CNT_W-1:0]  phase_cnt_t;
    typedef logic [STAT_W-1:0] stat_word_t;

    typedef enum logic [2:0] {
        TC_NORMAL  = 3'd0,
        TC_RETRY   = 3'd1,
        TC_DISC    = 3'd2,
        TC_TABORT  = 3'd3,
        TC_MABORT  = 3'd4,
        TC_TIMEOUT = 3'd5,
        TC_RSV6    = 3'd6,
        TC_RSV7    = 3'd7
    } term_cause_e;

    typedef struct packed {
        term_cause_e cause;
        logic        cnt_en;
        phase_cnt_t  outstanding;
    } term_evt_t;

    function automatic logic cause_known(term_cause_e c);
        return (c != TC_RSV6) && (c != TC_RSV7);
    endfunction

    function automatic stat_word_t pack_status(term_evt_t e);
        stat_word_t w;
        phase_cnt_t rc;
        w  = '0;
        rc = '0;
        if (e.cnt_en && (e.cause != TC_NORMAL) && (e.outstanding != '0))
            rc = e.outstanding - phase_cnt_t'(1);
        w[RC_LSB +: CNT_W] = rc;
        case (e.cause)
            TC_RETRY:   w[BIT_RETRY]   = 1'b1;
            TC_DISC:    w[BIT_DISC]    = 1'b1;
            TC_TABORT:  w[BIT_TABORT]  = 1'b1;
            TC_MABORT:  w[BIT_MABORT]  = 1'b1;
            TC_TIMEOUT: w[BIT_TIMEOUT] = 1'b1;
            default:    ;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/burst_phase_ctr.sv
module burst_phase_ctr
    import burst_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  phase_cnt_t len_i,
    input  logic       dec_i,
    output phase_cnt_t outst_o
);

    phase_cnt_t cnt_q;
    logic       step;

    assign step    = dec_i && (cnt_q != '0);
    assign outst_o = step ? cnt_q - phase_cnt_t'(1) : cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= len_i;
        else if (step)
            cnt_q <= cnt_q - phase_cnt_t'(1);
    end

endmodule

// File: rtl/burst_stat_fmt.sv
module burst_stat_fmt
    import burst_stat_pkg::*;
(
    input  logic [2:0] cause_i,
    input  logic       cnt_en_i,
    input  phase_cnt_t outst_i,
    output logic       known_o,
    output stat_word_t word_o
);

    term_evt_t evt;

    always_comb begin
        evt.cause       = term_cause_e'(cause_i);
        evt.cnt_en      = cnt_en_i;
        evt.outstanding = outst_i;
        known_o         = cause_known(evt.cause);
        word_o          = pack_status(evt);
    end

endmodule

// File: rtl/burst_stat_tracker.sv
module burst_stat_tracker
    import burst_stat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [CNT_W-1:0]     burst_len_i,
    input  logic                 cnt_en_i,
    input  logic                 master_i,
    input  logic                 phase_done_i,
    input  logic                 term_valid_i,
    input  logic [2:0]           term_cause_i,
    output logic [STAT_W-1:0]    status_o
);

    phase_cnt_t outst;
    stat_word_t next_word;
    logic       known;
    logic       capture;
    stat_word_t stat_q;

    burst_phase_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (start_i),
        .len_i   (burst_len_i),
        .dec_i   (phase_done_i),
        .outst_o (outst)
    );

    burst_stat_fmt u_fmt (
        .cause_i  (term_cause_i),
        .cnt_en_i (cnt_en_i),
        .outst_i  (outst),
        .known_o  (known),
        .word_o   (next_word)
    );

    assign capture = term_valid_i && master_i && known;

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else if (capture)
            stat_q <= next_word;
    end

    assign status_o = stat_q;

endmodule

// File: rtl/burst_stat_chk.sv
module burst_stat_chk
    import burst_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cnt_en_i,
    input logic              master_i,
    input logic              term_valid_i,
    input logic [2:0]        term_cause_i,
    input logic [STAT_W-1:0] status_o
);

    logic [5:0] flags;
    assign flags = {status_o[5:4], status_o[2:0]};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status_o == '0));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (status_o[23:22] == 2'b0) && (status_o[15:6] == '0) && !status_o[3]);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(term_valid_i && master_i) |=> $stable(status_o));

    assert_normal_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (term_valid_i && master_i && term_cause_i == 3'd0) |=> (status_o == '0));

    assert_disabled_count_R7: assert property (@(posedge clk) disable iff (rst)
        (term_valid_i && master_i && !cnt_en_i && term_cause_i <= 3'd5)
        |=> (status_o[21:16] == '0));

    assert_one_flag_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flags));

    assert_unknown_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (term_cause_i >= 3'd6) |=> $stable(status_o));

endmodule

bind burst_stat_tracker burst_stat_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .cnt_en_i     (cnt_en_i),
    .master_i     (master_i),
    .term_valid_i (term_valid_i),
    .term_cause_i (term_cause_i),
    .status_o     (status_o)
);

// File: tb/burst_stat_tracker_tb_top.sv
module burst_stat_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [5:0]  burst_len_i;
    logic        cnt_en_i;
    logic        master_i;
    logic        phase_done_i;
    logic        term_valid_i;
    logic [2:0]  term_cause_i;
    logic [23:0] status_o;

    always #10ns clk = ~clk;

    burst_stat_tracker dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .burst_len_i  (burst_len_i),
        .cnt_en_i     (cnt_en_i),
        .master_i     (master_i),
        .phase_done_i (phase_done_i),
        .term_valid_i (term_valid_i),
        .term_cause_i (term_cause_i),
        .status_o     (status_o)
    );

    typedef struct {
        logic [23:0] exp;
        int          due;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;
    int          m_cnt = 0;
    logic [23:0] m_stat = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each expected word in the cycle it is due
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (status_o !== it.exp) begin
                n_errors++;
                $display("FAIL %s: status actual %06h expected %06h", it.tag, status_o, it.exp);
            end
        end
    end

    function automatic int flag_bit(int c);
        case (c)
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 5;
            5: return 0;
            default: return -1;
        endcase
    endfunction

    task automatic push(logic [23:0] e, string tag);
        item_t it;
        it.exp = e; it.due = cyc + 1; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst = 1'b1;
        m_stat = '0; m_cnt = 0;
        push(24'h0, tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_start(int len, bit with_phase);
        @(negedge clk);
        start_i = 1'b1; burst_len_i = 6'(len); phase_done_i = with_phase;
        m_cnt = len;  // R10: reload wins over a same-cycle strobe
        @(negedge clk);
        start_i = 1'b0; phase_done_i = 1'b0;
    endtask

    task automatic do_phases(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            phase_done_i = 1'b1;
            if (m_cnt > 0) m_cnt--;
        end
        @(negedge clk);
        phase_done_i = 1'b0;
    endtask

    task automatic do_term(int cause, bit en, bit mst, bit ph, string tag);
        int out;
        logic [23:0] w;
        @(negedge clk);
        term_valid_i = 1'b1; term_cause_i = 3'(cause);
        cnt_en_i = en; master_i = mst; phase_done_i = ph;
        out = (ph && m_cnt > 0) ? m_cnt - 1 : m_cnt;
        if (mst && cause <= 5) begin
            w = '0;
            if (cause != 0) w[flag_bit(cause)] = 1'b1;
            if (en && cause != 0 && out > 0) w[21:16] = 6'(out - 1);
            m_stat = w;
        end
        m_cnt = out;
        push(m_stat, tag);
        @(negedge clk);
        term_valid_i = 1'b0; phase_done_i = 1'b0; master_i = 1'b1; cnt_en_i = 1'b1;
    endtask

    initial begin
        rst = 1'b1; start_i = 0; burst_len_i = 0; cnt_en_i = 1; master_i = 1;
        phase_done_i = 0; term_valid_i = 0; term_cause_i = 0;
        repeat (2) @(negedge clk);
        do_reset("R1 reset clears status");

        do_start(8, 0); do_phases(3);
        do_term(1, 1, 1, 0, "R6/R2 retry after 3 of 8");
        do_start(8, 0); do_phases(8);
        do_term(0, 1, 1, 0, "R5 normal completion");
        do_start(10, 0); do_phases(2);
        do_term(2, 0, 1, 0, "R7 disconnect counter off");
        do_start(4, 0); do_phases(1);
        do_term(3, 1, 1, 1, "R6 target abort with same-cycle phase");
        do_term(1, 1, 0, 0, "R4 not master ignored");
        do_term(6, 1, 1, 0, "R9 code 6 ignored");
        do_term(7, 1, 1, 0, "R9 code 7 ignored");
        do_start(63, 0);
        do_term(5, 1, 1, 0, "R8 timeout full burst");
        do_start(3, 0); do_phases(3);
        do_term(4, 1, 1, 0, "R8 master abort none outstanding");
        do_start(2, 0); do_phases(4);
        do_term(1, 1, 1, 0, "R3 counter holds at zero");
        do_start(5, 1);
        do_term(2, 1, 1, 0, "R10 reload wins over phase");
        do_start(1, 0);
        do_term(5, 1, 1, 0, "R6 one outstanding stores zero");
        do_start(20, 0); do_phases(5);
        do_term(3, 1, 1, 0, "R2 target abort mid burst");
        do_reset("R1 reset after capture");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++; n_errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #2ms;
        if (!done) begin
            done = 1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: run not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule